// File: doc/BRIEF.md
# Frame Base Latch with Update Interrupt

This block keeps the start address of the framebuffer for a raster display controller. Software may program a new base address whenever it likes. The value waits in a holding register and moves into the live fetch address only when the display timing generator marks the first clock of a new frame. The address that drives the frame-start fetch therefore never changes partway through a frame.

Each commit also raises an "update done" status bit. When software enables that bit, it drives the single interrupt line, and software uses the interrupt as its vertical-blank tick. The register interface has five registers: the holding base, an interrupt enable mask, raw status, masked status and a write-one-to-clear register.

The block has no line-pitch register. The fetch stride for each line is the active width times the bytes per pixel, and the fetch logic downstream of this block derives it.

Top module: `fb_base_latch`

## Requirements
- R1: After synchronous reset, `frame_base` is 0, `irq` is 0, and the holding base, enable and raw status all read as 0.
- R2: A write to offset 0 stores the written value with its two lowest bits forced to 0, and offset 0 reads that stored value back. Every `frame_base` value has bits [1:0] equal to 0.
- R3: `frame_base` does not change on a cycle without `frame_start`. On the edge where `frame_start` is high, `frame_base` takes the holding value from before that edge. A holding-register write in that same cycle affects only the next frame.
- R4: Raw status bit 0 (offset 2) is set on the edge where `frame_start` is high, whatever the enable mask holds.
- R5: Masked status (offset 3) reads raw status AND enable, and it reads as zero when no enabled event is pending.
- R6: `irq` is registered and equals the OR of the masked status bits in the same cycle that the status registers change.
- R7: Writing 1 to bit 0 of the clear register (offset 4) clears raw bit 0. Writing 0 there has no effect, and offset 4 reads as 0.
- R8: When a commit and a clear of the same status bit fall in one cycle, the bit ends up set.
- R9: Offset 1 stores enable bit 0, and only that bit. Writing 0 masks the source, and writing 1 enables it.
- R10: Offsets 5 to 7 read as 0. Writes to offsets 2, 3 and 5 to 7 change no register.
- R11: Read data is registered: `reg_rdata` shows, one edge after `reg_sel` is presented, the register contents as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe on the first clock of a frame |
| reg_sel | input | 3 | Register word offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| frame_base | output | 32 | Active frame-start DMA base address |
| irq | output | 1 | Interrupt line |

## Verification
Random traffic mixes register writes to every offset, including unaligned addresses and writes to read-only or unmapped offsets, with sparse frame strobes. This shows that the live address moves only on a strobe and that stray writes leave all state alone. Directed cases place a clear and a commit on the same edge, and a holding-register write on the strobe edge. These cases separate set-over-clear priority and old-value commit from their wrong orderings. Sweeps of the enable mask with status pending and with status idle separate masked from raw status on both the read port and `irq`.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    OFS_HOLD   = 3'd0,
    OFS_ENABLE = 3'd1,
    OFS_RAW    = 3'd2,
    OFS_MASKED = 3'd3,
    OFS_CLEAR  = 3'd4
  } reg_ofs_e;
  localparam int UPD_BIT = 0;
endpackage

// File: rtl/fbl_base_buf.sv
module fbl_base_buf #(
  parameter int AW    = 32,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          commit,
  output logic [AW-1:0] pending,
  output logic [AW-1:0] active
);
  localparam logic [AW-1:0] KEEP = {{(AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      active  <= '0;
    end else begin
      if (commit) active <= pending;
      if (wr_en)  pending <= wr_data & KEEP;
    end
  end
endmodule

// File: rtl/fbl_irq_ctrl.sv
module fbl_irq_ctrl #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_ev,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] en,
  output logic            irq
);
  logic [NSRC-1:0] raw_nx;
  logic [NSRC-1:0] en_nx;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      if (set_ev[i])                  raw_nx[i] = 1'b1;
      else if (clr_we && clr_mask[i]) raw_nx[i] = 1'b0;
      else                            raw_nx[i] = raw[i];
    end
  end

  assign en_nx = en_we ? en_wdata : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      raw <= raw_nx;
      en  <= en_nx;
      irq <= |(raw_nx & en_nx);
    end
  end
endmodule

// File: rtl/fb_base_latch.sv
module fb_base_latch #(
  parameter int AW   = 32,
  parameter int NSRC = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic [fbl_pkg::SEL_W-1:0] reg_sel,
  input  logic                    reg_we,
  input  logic [AW-1:0]           reg_wdata,
  output logic [AW-1:0]           reg_rdata,
  output logic [AW-1:0]           frame_base,
  output logic                    irq
);
  import fbl_pkg::*;

  logic [AW-1:0]   pend_q;
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] set_vec;
  logic            wr_hold, wr_en_reg, wr_clr;

  assign wr_hold   = reg_we && (reg_sel == OFS_HOLD);
  assign wr_en_reg = reg_we && (reg_sel == OFS_ENABLE);
  assign wr_clr    = reg_we && (reg_sel == OFS_CLEAR);

  always_comb begin
    set_vec          = '0;
    set_vec[UPD_BIT] = frame_start;
  end

  fbl_base_buf #(.AW(AW), .ALIGN(2)) u_base (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_hold),
    .wr_data (reg_wdata),
    .commit  (frame_start),
    .pending (pend_q),
    .active  (frame_base)
  );

  fbl_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_ev   (set_vec),
    .en_we    (wr_en_reg),
    .en_wdata (reg_wdata[NSRC-1:0]),
    .clr_we   (wr_clr),
    .clr_mask (reg_wdata[NSRC-1:0]),
    .raw      (raw_q),
    .en       (en_q),
    .irq      (irq)
  );

  logic [AW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_sel)
      OFS_HOLD:   rd_mux = pend_q;
      OFS_ENABLE: rd_mux[NSRC-1:0] = en_q;
      OFS_RAW:    rd_mux[NSRC-1:0] = raw_q;
      OFS_MASKED: rd_mux[NSRC-1:0] = raw_q & en_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/fbl_checker.sv
module fbl_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic [2:0]    reg_sel,
  input logic          reg_we,
  input logic [AW-1:0] reg_wdata,
  input logic [AW-1:0] frame_base,
  input logic [AW-1:0] pend,
  input logic          raw0,
  input logic          en0,
  input logic          irq
);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(frame_base));
  p_commit_r3: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> frame_base == $past(pend));
  p_align_r2: assert property (@(posedge clk) disable iff (rst)
    frame_base[1:0] == 2'b00);
  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> raw0);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 3'd4 && reg_wdata[0] && !frame_start) |=> !raw0);
  p_line_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (raw0 && en0));
  p_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 3'd1 && !reg_wdata[0]) |=> !irq);
endmodule

bind fb_base_latch fbl_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .reg_sel     (reg_sel),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .frame_base  (frame_base),
  .pend        (pend_q),
  .raw0        (raw_q[0]),
  .en0         (en_q[0]),
  .irq         (irq)
);

// File: tb/sim_fb_base_latch.sv
module sim_fb_base_latch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] frame_base;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pend = 0, m_act = 0;
  logic        m_en = 0, m_raw = 0;

  always #4 clk = ~clk;

  fb_base_latch u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_base(frame_base), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] s);
    case (s)
      3'd0: return m_pend;
      3'd1: return {31'd0, m_en};
      3'd2: return {31'd0, m_raw};
      3'd3: return {31'd0, m_raw & m_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R9";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic we, input logic [31:0] d, input logic fs);
    logic [31:0] erd;
    @(negedge clk);
    reg_sel = s; reg_we = we; reg_wdata = d; frame_start = fs;
    erd = exp_read(s);
    @(posedge clk);
    if (fs) m_act = m_pend;
    if (we && s == 3'd0) m_pend = d & 32'hFFFF_FFFC;
    if (we && s == 3'd1) m_en = d[0];
    if (fs) m_raw = 1'b1;
    else if (we && s == 3'd4 && d[0]) m_raw = 1'b0;
    #1;
    chk("R3", frame_base, m_act);
    chk("R6", {31'd0, irq}, {31'd0, m_raw & m_en});
    chk({"R11/", read_tag(s)}, reg_rdata, erd);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4099));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", frame_base, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);
    for (int k = 0; k < 4; k++) step(k[2:0], 1'b0, 0, 1'b0);

    step(3'd0, 1'b1, 32'h1234_5677, 1'b0);   // R2 unaligned write
    step(3'd0, 1'b0, 0, 1'b0);
    chk("R2", reg_rdata, 32'h1234_5674);
    step(3'd3, 1'b0, 0, 1'b1);               // R3 commit, R4 raw set with enable off
    step(3'd3, 1'b0, 0, 1'b0);               // R5 masked zero while disabled
    step(3'd1, 1'b1, 32'hFFFF_FFFF, 1'b0);   // R9 enable only bit 0
    step(3'd1, 1'b0, 0, 1'b0);
    step(3'd4, 1'b1, 32'd0, 1'b0);           // R7 writing zero does nothing
    step(3'd4, 1'b1, 32'd1, 1'b1);           // R8 set beats clear
    step(3'd2, 1'b0, 0, 1'b0);
    step(3'd4, 1'b1, 32'd1, 1'b0);           // R7 clear
    step(3'd0, 1'b1, 32'hABCD_0000, 1'b1);   // R3 write on strobe edge
    step(3'd0, 1'b0, 0, 1'b1);
    step(3'd6, 1'b1, 32'hFFFF_FFFF, 1'b0);   // R10 stray writes
    step(3'd2, 1'b1, 32'd0, 1'b0);
    step(3'd6, 1'b0, 0, 1'b0);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  s  = 3'($urandom_range(0, 7));
      logic        we = 1'($urandom_range(0, 1));
      logic [31:0] d  = $urandom;
      logic        fs = ($urandom_range(0, 7) == 0);
      if (s == 3'd4 || s == 3'd1) d[0] = 1'($urandom_range(0, 1));
      step(s, we, d, fs);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule